// File: doc/BRIEF.md
# Queued Serial Transmitter with Deferred Shutdown

This block is the transmit half of an asynchronous serial port. A host pushes bytes through a write port into a 16-entry queue, and a serializer sends them as 8-N-1 frames on a line that idles high. Bit timing comes from an external single-cycle baud tick, and every bit of a frame lasts exactly one tick period. When the queue holds more bytes, frames follow each other with no idle time between them.

The host controls the block with two command strobes. An enable command starts the transmitter. While the transmitter is enabled and the queue is empty, the interrupt output asks for more data. This is also true straight after an enable command, so software can fill the queue from its interrupt handler.

A disable command drops the interrupt at once, so a handler with nothing left to send can leave without being re-entered. The disable does not stop the line right away. The serializer keeps running until every byte already queued, and the frame in flight, have gone out. Only then does the active output fall. Bytes written while the transmitter is stopped wait in the queue until the next enable. Writes to a full queue are dropped, and they set a sticky overflow flag.

Top module: `txq_uart`

## Requirements
- R1: After reset, txd_o is 1, irq_o is 0, room_o is 1, ovf_o is 0 and active_o is 0.
- R2: Each frame is a start bit of 0, then eight data bits with bit 0 first, then a stop bit of 1. Every bit starts on a posedge where baud_tick_i is 1 and lasts until the next such posedge. txd_o is 1 whenever no frame is in progress.
- R3: The queue holds 16 bytes, and room_o is 0 exactly when 16 bytes are waiting. Bytes are transmitted in the order they were accepted.
- R4: irq_o is 1 exactly when the transmitter is enabled and the queue is empty. An enable command given while the queue is empty raises irq_o on the next cycle.
- R5: An accepted write clears irq_o on the next cycle. irq_o rises again when the last queued byte is moved into the serializer.
- R6: A disable command clears irq_o on the next cycle. The queued bytes and the frame in flight are still sent. active_o falls only after the last stop bit has completed.
- R7: While the transmitter is stopped, written bytes are queued but not sent, and txd_o stays 1. A later enable command sends them.
- R8: A write while room_o is 0 is discarded and sets ovf_o. ovf_o then stays 1 until reset.
- R9: While the queue still holds data, the next start bit directly follows the previous stop bit, with no idle bit between them.
- R10: When tx_enable_i and tx_disable_i are both 1 in the same cycle, the disable takes effect and the enable is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Single-cycle strobe that marks each bit boundary |
| wr_en_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | 8 | Byte to queue |
| tx_enable_i | input | 1 | Enable command strobe |
| tx_disable_i | input | 1 | Disable command strobe (deferred shutdown) |
| room_o | output | 1 | Queue has room for another byte |
| ovf_o | output | 1 | Sticky flag: a write hit a full queue |
| irq_o | output | 1 | Transmitter is enabled and the queue is empty |
| active_o | output | 1 | Transmitter is running, either enabled or draining |
| txd_o | output | 1 | Serial output line |

## Verification
The bench first fills the queue while the transmitter is stopped and then pushes one byte past full. A design with an off-by-one depth would report room too early or too late. A design that accepts the extra byte would send a stray frame or fail to set the overflow flag.

It issues a disable while a burst is in flight. A design that shuts down at once would lose the tail bytes. A design that masks the interrupt late would leave irq_o high after the command.

The bench also enables the transmitter on an empty queue, where a design that waits for a first byte would never interrupt. It sends a long burst, where any idle bit between frames shows up as a measured gap. Finally it gives both commands together, where giving the enable priority would leave the transmitter running.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_DATA_W = 8;
  localparam int unsigned TXQ_DEPTH  = 16;

  typedef struct packed {
    logic en;     // enabled by command
    logic drain;  // disabled, still flushing queue and shifter
  } txq_run_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/txq_shift.sv
module txq_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_ok_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  // reload on the tick that ends the stop bit, so frames run back to back
  assign pop_o  = tick_i && start_ok_i && (cnt_q <= CNT_W'(1));
  assign busy_o = (cnt_q != '0);
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (pop_o) begin
        sh_q  <= {1'b1, data_i, 1'b0};
        cnt_q <= CNT_W'(FRAME_W);
      end else if (cnt_q > CNT_W'(1)) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/txq_uart.sv
module txq_uart
  import txq_pkg::*;
#(
  parameter int unsigned DATA_W = TXQ_DATA_W,
  parameter int unsigned DEPTH  = TXQ_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_enable_i,
  input  logic              tx_disable_i,
  output logic              room_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              active_o,
  output logic              txd_o
);
  logic              fifo_empty, fifo_full, push, pop, shift_busy, running;
  logic [DATA_W-1:0] head;
  txq_run_t          run_q, run_d;
  logic              ovf_q;

  assign push    = wr_en_i && !fifo_full;
  assign running = run_q.en || run_q.drain;

  txq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  txq_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (baud_tick_i),
    .start_ok_i (running && !fifo_empty),
    .data_i     (head),
    .pop_o      (pop),
    .busy_o     (shift_busy),
    .txd_o      (txd_o)
  );

  // disable wins over enable; a stopped idle transmitter does not drain
  always_comb begin
    run_d = run_q;
    if (tx_disable_i) begin
      run_d.en    = 1'b0;
      run_d.drain = running && (!fifo_empty || shift_busy);
    end else if (tx_enable_i) begin
      run_d.en    = 1'b1;
      run_d.drain = 1'b0;
    end else if (run_q.drain && fifo_empty && !shift_busy) begin
      run_d.drain = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (wr_en_i && fifo_full) ovf_q <= 1'b1;
    end
  end

  assign room_o   = !fifo_full;
  assign ovf_o    = ovf_q;
  assign irq_o    = run_q.en && fifo_empty;
  assign active_o = running;
endmodule

// File: rtl/txq_uart_chk.sv
module txq_uart_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic wr_en_i,
  input logic tx_enable_i,
  input logic tx_disable_i,
  input logic room_o,
  input logic ovf_o,
  input logic irq_o,
  input logic active_o,
  input logic txd_o,
  input logic fifo_empty_i
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> txd_o);

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o));

  // R4
  irq_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> room_o);

  // R4
  enable_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_enable_i && !tx_disable_i && !wr_en_i && fifo_empty_i) |=> irq_o);

  // R5
  write_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && room_o) |=> !irq_o);

  // R6
  disable_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_disable_i |=> !irq_o);

  // R8
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !room_o) |=> ovf_o);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

bind txq_uart txq_uart_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .baud_tick_i  (baud_tick_i),
  .wr_en_i      (wr_en_i),
  .tx_enable_i  (tx_enable_i),
  .tx_disable_i (tx_disable_i),
  .room_o       (room_o),
  .ovf_o        (ovf_o),
  .irq_o        (irq_o),
  .active_o     (active_o),
  .txd_o        (txd_o),
  .fifo_empty_i (fifo_empty)
);

// File: tb/txq_uart_tb.sv
module txq_uart_tb;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       en_cmd = 1'b0, dis_cmd = 1'b0;
  logic       room, ovf, irq, active, txd;

  always #5 clk = ~clk;

  txq_uart u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_enable_i(en_cmd), .tx_disable_i(dis_cmd),
    .room_o(room), .ovf_o(ovf), .irq_o(irq), .active_o(active), .txd_o(txd)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  int model_cnt = 0, gaps = 0, idle_run = 0, rx_state = 0;
  logic [7:0] rx_sr = '0;
  logic tick_at_edge = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      baud_tick = (div == TICK_DIV - 1);
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
    end
  end

  always @(posedge clk) tick_at_edge <= baud_tick;

  // bench-side line receiver: one sample per bit, right after each tick edge
  always @(negedge clk) begin
    if (rst_n && tick_at_edge) begin
      if (rx_state == 0) begin
        if (txd == 1'b0) begin
          if (rx_q.size() > 0) gaps += idle_run;
          idle_run = 0;
          model_cnt--;
          rx_state = 1;
        end else begin
          idle_run++;
        end
      end else if (rx_state <= 8) begin
        rx_sr[rx_state-1] = txd;
        rx_state++;
      end else begin
        chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
        rx_q.push_back(rx_sr);
        rx_state = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    if (model_cnt < 16) begin
      exp_q.push_back(b);
      model_cnt++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input bit e, input bit d);
    @(negedge clk);
    en_cmd = e;
    dis_cmd = d;
    @(negedge clk);
    en_cmd = 1'b0;
    dis_cmd = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_q.size() < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    chk(rx_q.size() == exp_q.size(), {req, " frame count"}, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], {req, " byte"}, int'(rx_q[i]), int'(exp_q[i]));
    rx_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b1,   "R1 txd",    int'(txd), 1);
    chk(irq == 1'b0,   "R1 irq",    int'(irq), 0);
    chk(room == 1'b1,  "R1 room",   int'(room), 1);
    chk(ovf == 1'b0,   "R1 ovf",    int'(ovf), 0);
    chk(active == 1'b0,"R1 active", int'(active), 0);

    // R4: enable on empty queue
    cmd(1, 0);
    chk(irq == 1'b1, "R4 irq after enable", int'(irq), 1);
    chk(active == 1'b1, "R4 active after enable", int'(active), 1);

    // R5: a write drops irq, which returns once the byte leaves the queue
    wr(8'hA5);
    chk(irq == 1'b0, "R5 irq after write", int'(irq), 0);
    wait_rx(1);
    chk(irq == 1'b1, "R5 irq after last pop", int'(irq), 1);
    cmp_stream("R2");
    idle(3 * TICK_DIV);
    chk(txd == 1'b1, "R2 idle line", int'(txd), 1);

    // R10: both commands in one cycle
    cmd(1, 1);
    chk(irq == 1'b0, "R10 irq", int'(irq), 0);
    chk(active == 1'b0, "R10 active", int'(active), 0);

    // R3/R8: fill while stopped, then overflow
    for (int i = 0; i < 16; i++) wr(8'(8'h10 + i * 7));
    chk(room == 1'b0, "R3 full at 16", int'(room), 0);
    chk(irq == 1'b0, "R4 irq while disabled", int'(irq), 0);
    wr(8'hEE);
    chk(ovf == 1'b1, "R8 ovf set", int'(ovf), 1);
    chk(room == 1'b0, "R8 room still 0", int'(room), 0);
    idle(15 * TICK_DIV);
    chk(rx_q.size() == 0, "R7 no frames while stopped", rx_q.size(), 0);
    chk(txd == 1'b1, "R7 line high while stopped", int'(txd), 1);

    // R9: burst from a full queue
    gaps = 0;
    cmd(1, 0);
    chk(irq == 1'b0, "R5 no irq with data queued", int'(irq), 0);
    wait_rx(16);
    chk(gaps == 0, "R9 idle bits between frames", gaps, 0);
    cmp_stream("R3");
    idle(2);
    chk(irq == 1'b1, "R5 irq after burst", int'(irq), 1);
    chk(ovf == 1'b1, "R8 ovf sticky", int'(ovf), 1);
    chk(room == 1'b1, "R3 room after drain", int'(room), 1);
    idle(3 * TICK_DIV);

    // R6: disable mid-stream
    for (int i = 0; i < 5; i++) wr(8'(8'hC3 ^ (i * 29)));
    wait_rx(1);
    cmd(0, 1);
    chk(irq == 1'b0, "R6 irq after disable", int'(irq), 0);
    chk(active == 1'b1, "R6 still draining", int'(active), 1);
    wait_rx(5);
    idle(3 * TICK_DIV);
    chk(active == 1'b0, "R6 idle after drain", int'(active), 0);
    cmp_stream("R6");

    // R7: writes while stopped wait for enable
    wr(8'h3C);
    wr(8'h81);
    idle(15 * TICK_DIV);
    chk(rx_q.size() == 0, "R7 held while stopped", rx_q.size(), 0);
    cmd(1, 0);
    wait_rx(2);
    cmp_stream("R7");

    // R3: random traffic, order preserved
    for (int i = 0; i < 60; i++) begin
      idle($urandom_range(0, 40));
      if (model_cnt <= 14) wr(8'($urandom_range(0, 255)));
    end
    wait_rx(exp_q.size());
    cmp_stream("R3 random");
    idle(3 * TICK_DIV);
    chk(txd == 1'b1, "R2 idle after random", int'(txd), 1);

    finish_run();
  end
endmodule